// File: doc/BRIEF.md
# I2C Slave FIFO Service Controller

This block connects an I2C slave byte engine to the transmit and receive FIFOs that sit outside it. It turns engine events into sticky interrupt flags for the CPU and into DMA request handshakes. The FIFOs, the DMA engine and the bit-level shifter are outside the block. The block reaches them through level inputs (FIFO fill counts), single-cycle strobes (addressing, stop, NACK, flush) and request/acknowledge pairs.

When the master addresses the slave for a write, the block flags the CPU. It also raises a receive flag whenever the RX fill count reaches a programmed threshold. When the master addresses the slave for a read, the block first flushes stale TX data for one cycle and only then flags the CPU. While the master wants a byte and the TX FIFO is empty, the block holds the bus clock low and raises a dry flag. On the closing NACK, it raises a done flag and latches a status word. In DMA mode it issues TX single or burst requests and RX single requests. A NACK during a DMA read ends TX activity with one extra request marked last.

The thresholds and the burst size are copied into shadow registers only while no transfer is in progress.

Top module: `i2c_slave_fifo_svc`

## Requirements
- R1: A write addressing strobe while idle sets flag bit 0 on the following clock edge and starts a write transfer, which ends on the stop strobe.
- R2: Flag bit 1 is set on every edge at which the RX fill count is greater than or equal to the shadow RX threshold.
- R3: Flag bit 2 is set on every edge at which the TX fill count is less than or equal to the shadow TX threshold.
- R4: A read addressing strobe while idle gives a one-cycle flush pulse on the next cycle. Flag bit 3 is set on the edge that ends that pulse, and the read phase starts there.
- R5: In the read phase, while byte request is high and the TX count is zero, the clock-hold output is high in the same cycle and flag bit 4 is set at the edge.
- R6: A NACK strobe in the read phase sets flag bit 5, latches the status input into the status output and returns the block to idle.
- R7: In the read phase with DMA on and no TX request pending, the block raises a burst request. It does so when the shadow burst size is above 1 and the free space (16 minus the TX count) is at least that size. Otherwise it raises a single request when free space is nonzero. A request stays high until the acknowledge, and single and burst are never high together.
- R8: A NACK in the DMA read phase replaces any pending TX request with a last request: a burst when the burst size is above 1, otherwise a single, with the last output high until acknowledged.
- R9: With DMA on, a nonzero RX count raises an RX single request, held until its acknowledge.
- R10: Flags are sticky and cleared by the matching bit of the write-one-to-clear strobe; a set in the same cycle wins. The interrupt output is the OR of the flags ANDed with the enable mask.
- R11: Threshold and burst inputs changed during a transfer have no effect until the block is idle again.
- R12: During reset all flags, requests, the flush pulse, the clock-hold output and the status output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr_i | input | 1 | Strobe: addressed for a master write |
| addr_rd_i | input | 1 | Strobe: addressed for a master read |
| stop_i | input | 1 | Strobe: write transfer ended |
| nack_i | input | 1 | Strobe: master NACKed the last read byte |
| byte_req_i | input | 1 | Engine wants the next TX byte |
| status_i | input | STAT_W | Transfer status to latch at read end |
| tx_level_i | input | LVL_W | TX FIFO entry count |
| rx_level_i | input | LVL_W | RX FIFO entry count |
| tx_flush_o | output | 1 | One-cycle TX FIFO flush pulse |
| scl_hold_o | output | 1 | Hold bus clock low |
| dma_en_i | input | 1 | DMA mode enable |
| rx_thr_i | input | CFG_W | RX nearly-full threshold |
| tx_thr_i | input | CFG_W | TX nearly-empty threshold |
| burst_i | input | CFG_W | TX DMA burst size |
| irq_en_i | input | 6 | Interrupt enable mask per flag |
| clr_i | input | 6 | Write-one-to-clear strobe per flag |
| flags_o | output | 6 | Sticky flags (bits 0..5 as in R1..R6) |
| irq_o | output | 1 | Combined interrupt |
| status_o | output | STAT_W | Latched status of the last read |
| tx_sreq_o | output | 1 | TX DMA single request |
| tx_breq_o | output | 1 | TX DMA burst request |
| tx_last_o | output | 1 | Marks the final dummy TX request |
| tx_ack_i | input | 1 | TX DMA acknowledge |
| rx_sreq_o | output | 1 | RX DMA single request |
| rx_ack_i | input | 1 | RX DMA acknowledge |

## Verification
The properties assume that engine strobes last one cycle, that FIFO counts never exceed the depth of 16, and that an acknowledge arrives only while its request is high. The stimulus pulses each strobe for exactly one clock and raises an acknowledge only after it has seen the matching request. It keeps the counts between 0 and 16. It gives addressing strobes only while the block is idle, except for deliberate checks that events are ignored.

// File: rtl/i2c_svc_pkg.sv
package i2c_svc_pkg;

  localparam int NFLAGS      = 6;
  localparam int F_WR_ADDR   = 0;
  localparam int F_RX_HI     = 1;
  localparam int F_TX_LO     = 2;
  localparam int F_RD_ADDR   = 3;
  localparam int F_TX_DRY    = 4;
  localparam int F_RD_DONE   = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FLUSH = 2'd2,
    ST_READ  = 2'd3
  } xfer_st_t;

  function automatic logic at_or_above(input int level, input int thr);
    return level >= thr;
  endfunction

  function automatic logic at_or_below(input int level, input int thr);
    return level <= thr;
  endfunction

  function automatic int slots_free(input int depth, input int level);
    return depth - level;
  endfunction

  function automatic logic burst_fits(input int free, input int burst);
    return (burst > 1) && (free >= burst);
  endfunction

endpackage

// File: rtl/svc_sequencer.sv
module svc_sequencer
  import i2c_svc_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int CFG_W  = 4,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_i,
  input  logic              addr_rd_i,
  input  logic              stop_i,
  input  logic              nack_i,
  input  logic              byte_req_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [CFG_W-1:0]  rx_thr_i,
  input  logic [CFG_W-1:0]  tx_thr_i,
  input  logic [CFG_W-1:0]  burst_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [CFG_W-1:0]  rx_thr_q,
  output logic [CFG_W-1:0]  tx_thr_q,
  output logic [CFG_W-1:0]  burst_q,
  output logic [STAT_W-1:0] status_q,
  output logic              busy_o,
  output logic              rd_active_o,
  output logic              tx_flush_o,
  output logic              scl_hold_o,
  output logic              ev_wr_addr,
  output logic              ev_rd_ready,
  output logic              ev_tx_dry,
  output logic              ev_rd_done
);

  xfer_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (addr_wr_i)      st_d = ST_WRITE;
        else if (addr_rd_i) st_d = ST_FLUSH;
      end
      ST_WRITE: if (stop_i) st_d = ST_IDLE;
      ST_FLUSH: st_d = ST_READ;
      ST_READ:  if (nack_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // configuration shadow: follows the inputs only between transfers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= '0;
      tx_thr_q <= '0;
      burst_q  <= '0;
    end else if (st_q == ST_IDLE) begin
      rx_thr_q <= rx_thr_i;
      tx_thr_q <= tx_thr_i;
      burst_q  <= burst_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (ev_rd_done) status_q <= status_i;
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign rd_active_o = (st_q == ST_READ);
  assign ev_wr_addr  = (st_q == ST_IDLE) && addr_wr_i;
  assign ev_rd_ready = (st_q == ST_FLUSH);
  assign tx_flush_o  = (st_q == ST_FLUSH);
  assign scl_hold_o  = rd_active_o && byte_req_i && (tx_level_i == '0);
  assign ev_tx_dry   = scl_hold_o;
  assign ev_rd_done  = rd_active_o && nack_i;

endmodule

// File: rtl/svc_flag_bank.sv
module svc_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[g] <= 1'b0;
      else if (set_i[g]) flags_o[g] <= 1'b1;
      else if (clr_i[g]) flags_o[g] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & en_i);

endmodule

// File: rtl/svc_dma_ctl.sv
module svc_dma_ctl
  import i2c_svc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en_i,
  input  logic             rd_active_i,
  input  logic             rd_done_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [CFG_W-1:0] burst_q,
  input  logic             tx_ack_i,
  input  logic             rx_ack_i,
  output logic             tx_sreq_o,
  output logic             tx_breq_o,
  output logic             tx_last_o,
  output logic             rx_sreq_o
);

  logic tx_pend;
  logic big_burst;
  int   free_now;

  assign tx_pend   = tx_sreq_o | tx_breq_o;
  assign big_burst = int'(burst_q) > 1;
  assign free_now  = slots_free(DEPTH, int'(tx_level_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sreq_o <= 1'b0;
      tx_breq_o <= 1'b0;
      tx_last_o <= 1'b0;
    end else if (rd_done_i && dma_en_i) begin
      tx_breq_o <= big_burst;
      tx_sreq_o <= !big_burst;
      tx_last_o <= 1'b1;
    end else if (tx_ack_i) begin
      tx_sreq_o <= 1'b0;
      tx_breq_o <= 1'b0;
      tx_last_o <= 1'b0;
    end else if (!tx_pend && rd_active_i && dma_en_i) begin
      if (burst_fits(free_now, int'(burst_q))) tx_breq_o <= 1'b1;
      else if (free_now > 0)                  tx_sreq_o <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         rx_sreq_o <= 1'b0;
    else if (rx_ack_i)                                  rx_sreq_o <= 1'b0;
    else if (!rx_sreq_o && dma_en_i && rx_level_i != '0) rx_sreq_o <= 1'b1;
  end

endmodule

// File: rtl/i2c_slave_fifo_svc.sv
module i2c_slave_fifo_svc
  import i2c_svc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CFG_W      = 4,
  parameter int STAT_W     = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_i,
  input  logic              addr_rd_i,
  input  logic              stop_i,
  input  logic              nack_i,
  input  logic              byte_req_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              tx_flush_o,
  output logic              scl_hold_o,
  input  logic              dma_en_i,
  input  logic [CFG_W-1:0]  rx_thr_i,
  input  logic [CFG_W-1:0]  tx_thr_i,
  input  logic [CFG_W-1:0]  burst_i,
  input  logic [NFLAGS-1:0] irq_en_i,
  input  logic [NFLAGS-1:0] clr_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] status_o,
  output logic              tx_sreq_o,
  output logic              tx_breq_o,
  output logic              tx_last_o,
  input  logic              tx_ack_i,
  output logic              rx_sreq_o,
  input  logic              rx_ack_i
);

  logic [CFG_W-1:0]  rx_thr_q, tx_thr_q, burst_q;
  logic              xfer_busy, rd_active;
  logic              ev_wr_addr, ev_rd_ready, ev_tx_dry, ev_rd_done;
  logic              ev_rx_hi, ev_tx_lo;
  logic [NFLAGS-1:0] flag_set;

  svc_sequencer #(
    .LVL_W(LVL_W), .CFG_W(CFG_W), .STAT_W(STAT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_wr_i  (addr_wr_i),
    .addr_rd_i  (addr_rd_i),
    .stop_i     (stop_i),
    .nack_i     (nack_i),
    .byte_req_i (byte_req_i),
    .tx_level_i (tx_level_i),
    .rx_thr_i   (rx_thr_i),
    .tx_thr_i   (tx_thr_i),
    .burst_i    (burst_i),
    .status_i   (status_i),
    .rx_thr_q   (rx_thr_q),
    .tx_thr_q   (tx_thr_q),
    .burst_q    (burst_q),
    .status_q   (status_o),
    .busy_o     (xfer_busy),
    .rd_active_o(rd_active),
    .tx_flush_o (tx_flush_o),
    .scl_hold_o (scl_hold_o),
    .ev_wr_addr (ev_wr_addr),
    .ev_rd_ready(ev_rd_ready),
    .ev_tx_dry  (ev_tx_dry),
    .ev_rd_done (ev_rd_done)
  );

  assign ev_rx_hi = at_or_above(int'(rx_level_i), int'(rx_thr_q));
  assign ev_tx_lo = at_or_below(int'(tx_level_i), int'(tx_thr_q));

  always_comb begin
    flag_set            = '0;
    flag_set[F_WR_ADDR] = ev_wr_addr;
    flag_set[F_RX_HI]   = ev_rx_hi;
    flag_set[F_TX_LO]   = ev_tx_lo;
    flag_set[F_RD_ADDR] = ev_rd_ready;
    flag_set[F_TX_DRY]  = ev_tx_dry;
    flag_set[F_RD_DONE] = ev_rd_done;
  end

  svc_flag_bank #(.N(NFLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (clr_i),
    .en_i   (irq_en_i),
    .flags_o(flags_o),
    .irq_o  (irq_o)
  );

  svc_dma_ctl #(
    .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W), .CFG_W(CFG_W)
  ) u_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en_i   (dma_en_i),
    .rd_active_i(rd_active),
    .rd_done_i  (ev_rd_done),
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .burst_q    (burst_q),
    .tx_ack_i   (tx_ack_i),
    .rx_ack_i   (rx_ack_i),
    .tx_sreq_o  (tx_sreq_o),
    .tx_breq_o  (tx_breq_o),
    .tx_last_o  (tx_last_o),
    .rx_sreq_o  (rx_sreq_o)
  );

endmodule

// File: rtl/svc_checker.sv
module svc_checker #(
  parameter int NF    = 6,
  parameter int LVL_W = 5,
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NF-1:0]    flags_o,
  input logic [NF-1:0]    clr_i,
  input logic             tx_flush_o,
  input logic             scl_hold_o,
  input logic             nack_i,
  input logic [LVL_W-1:0] tx_level_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [CFG_W-1:0] rx_thr_q,
  input logic [CFG_W-1:0] burst_q,
  input logic             xfer_busy,
  input logic             tx_sreq_o,
  input logic             tx_breq_o,
  input logic             tx_last_o,
  input logic             tx_ack_i,
  input logic             rx_sreq_o,
  input logic             rx_ack_i
);

  a_r2_rx_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level_i) >= int'(rx_thr_q)) |=> flags_o[1]);

  a_r4_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[3]) |-> $past(tx_flush_o));

  a_r5_hold_only_dry: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o |-> (tx_level_i == '0));

  a_r6_done_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[5]) |-> $past(nack_i));

  a_r7_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_sreq_o && tx_breq_o));

  a_r7_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_sreq_o || tx_breq_o) && !tx_ack_i) |=> (tx_sreq_o || tx_breq_o));

  a_r8_last_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> (tx_sreq_o || tx_breq_o));

  a_r9_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sreq_o && !rx_ack_i) |=> rx_sreq_o);

  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> ($stable(rx_thr_q) && $stable(burst_q)));

  for (genvar g = 0; g < NF; g++) begin : g_sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
  end

endmodule

bind i2c_slave_fifo_svc svc_checker #(
  .NF(i2c_svc_pkg::NFLAGS), .LVL_W(LVL_W), .CFG_W(CFG_W)
) u_svc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flags_o   (flags_o),
  .clr_i     (clr_i),
  .tx_flush_o(tx_flush_o),
  .scl_hold_o(scl_hold_o),
  .nack_i    (nack_i),
  .tx_level_i(tx_level_i),
  .rx_level_i(rx_level_i),
  .rx_thr_q  (rx_thr_q),
  .burst_q   (burst_q),
  .xfer_busy (xfer_busy),
  .tx_sreq_o (tx_sreq_o),
  .tx_breq_o (tx_breq_o),
  .tx_last_o (tx_last_o),
  .tx_ack_i  (tx_ack_i),
  .rx_sreq_o (rx_sreq_o),
  .rx_ack_i  (rx_ack_i)
);

// File: tb/test_i2c_slave_fifo_svc.sv
module test_i2c_slave_fifo_svc;

  localparam int LW = 5;
  localparam int CW = 4;
  localparam int SW = 4;
  localparam int NF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic addr_wr = 0, addr_rd = 0, stop = 0, nack = 0, byte_req = 0, dma_en = 0;
  logic tx_ack = 0, rx_ack = 0;
  logic [SW-1:0] status_in = '0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic [CW-1:0] rx_thr = 4'd4, tx_thr = 4'd2, burst = 4'd4;
  logic [NF-1:0] irq_en = '1, clr = '0;

  logic tx_flush, scl_hold, irq, tx_sreq, tx_breq, tx_last, rx_sreq;
  logic [NF-1:0] flags;
  logic [SW-1:0] status_out;

  i2c_slave_fifo_svc i_i2c_slave_fifo_svc (
    .clk(clk), .rst_n(rst_n), .addr_wr_i(addr_wr), .addr_rd_i(addr_rd),
    .stop_i(stop), .nack_i(nack), .byte_req_i(byte_req), .status_i(status_in),
    .tx_level_i(tx_level), .rx_level_i(rx_level), .tx_flush_o(tx_flush),
    .scl_hold_o(scl_hold), .dma_en_i(dma_en), .rx_thr_i(rx_thr), .tx_thr_i(tx_thr),
    .burst_i(burst), .irq_en_i(irq_en), .clr_i(clr), .flags_o(flags), .irq_o(irq),
    .status_o(status_out), .tx_sreq_o(tx_sreq), .tx_breq_o(tx_breq),
    .tx_last_o(tx_last), .tx_ack_i(tx_ack), .rx_sreq_o(rx_sreq), .rx_ack_i(rx_ack)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 write, 2 flush, 3 read
  int m_st, m_rt, m_tt, m_bs, m_stat;
  bit [NF-1:0] m_fl;
  bit m_ts, m_tb, m_tl, m_rs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rt = 0; m_tt = 0; m_bs = 0; m_stat = 0;
      m_fl = '0; m_ts = 0; m_tb = 0; m_tl = 0; m_rs = 0;
    end else begin
      bit [NF-1:0] s;
      int nst, free;
      s = '0;
      if (m_st == 0 && addr_wr) s[0] = 1;
      if (int'(rx_level) >= m_rt) s[1] = 1;
      if (int'(tx_level) <= m_tt) s[2] = 1;
      if (m_st == 2) s[3] = 1;
      if (m_st == 3 && byte_req && tx_level == 0) s[4] = 1;
      if (m_st == 3 && nack) s[5] = 1;
      m_fl = (m_fl & ~clr) | s;
      if (m_st == 3 && nack) m_stat = int'(status_in);
      free = 16 - int'(tx_level);
      if (m_st == 3 && nack && dma_en) begin
        m_tb = (m_bs > 1); m_ts = !(m_bs > 1); m_tl = 1;
      end else if (tx_ack) begin
        m_tb = 0; m_ts = 0; m_tl = 0;
      end else if (!(m_ts || m_tb) && m_st == 3 && dma_en) begin
        if (m_bs > 1 && free >= m_bs) m_tb = 1;
        else if (free > 0) m_ts = 1;
      end
      if (rx_ack) m_rs = 0;
      else if (!m_rs && dma_en && rx_level != 0) m_rs = 1;
      nst = m_st;
      case (m_st)
        0: if (addr_wr) nst = 1; else if (addr_rd) nst = 2;
        1: if (stop) nst = 0;
        2: nst = 3;
        default: if (nack) nst = 0;
      endcase
      if (m_st == 0) begin
        m_rt = int'(rx_thr); m_tt = int'(tx_thr); m_bs = int'(burst);
      end
      m_st = nst;
    end
  end

  // per-cycle comparison, one time unit after each rising edge
  always begin
    @(posedge clk);
    #1;
    chk("R1 flag0", flags[0], m_fl[0]);
    chk("R2 flag1", flags[1], m_fl[1]);
    chk("R3 flag2", flags[2], m_fl[2]);
    chk("R4 flag3", flags[3], m_fl[3]);
    chk("R4 flush", tx_flush, m_st == 2);
    chk("R5 flag4", flags[4], m_fl[4]);
    chk("R5 hold", scl_hold, (m_st == 3) && byte_req && (tx_level == 0));
    chk("R6 flag5", flags[5], m_fl[5]);
    chk("R6 status", int'(status_out), m_stat);
    chk("R7 single", tx_sreq, m_ts);
    chk("R7 burst", tx_breq, m_tb);
    chk("R8 last", tx_last, m_tl);
    chk("R9 rx req", rx_sreq, m_rs);
    chk("R10 irq", irq, |(m_fl & irq_en));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R12 reset state
    chk("R12 flags", int'(flags), 0);
    chk("R12 reqs", int'({tx_sreq, tx_breq, tx_last, rx_sreq}), 0);
    chk("R12 flush/hold", int'({tx_flush, scl_hold}), 0);
    chk("R12 status", int'(status_out), 0);
    rst_n = 1;
    tick(3);
    // R3 TX low at count 0; R10 clear loses to set
    chk("R3 tx low", flags[2], 1);
    clr = 6'b000100; tick(1); clr = '0; tick(1);
    chk("R10 set wins", flags[2], 1);
    tx_level = 5'd5; tick(1);
    clr = 6'b000100; tick(1); clr = '0; tick(1);
    chk("R10 w1c", flags[2], 0);

    // write transfer
    addr_wr = 1; tick(1); addr_wr = 0;
    chk("R1 wr flag", flags[0], 1);
    for (int i = 1; i <= 5; i++) begin rx_level = LW'(i); tick(1); end
    chk("R2 rx high", flags[1], 1);
    rx_thr = 4'd15; rx_level = 5'd8; tick(1);
    clr = 6'b000010; tick(1); clr = '0; tick(1);
    chk("R11 old thr kept", flags[1], 1);
    stop = 1; tick(1); stop = 0; tick(2);
    clr = 6'b000011; tick(1); clr = '0; tick(1);
    chk("R11 new thr used", flags[1], 0);
    chk("R1 cleared", flags[0], 0);
    rx_thr = 4'd4; rx_level = '0; tick(2);

    // CPU read
    tx_level = 5'd3;
    addr_rd = 1; tick(1); addr_rd = 0;
    chk("R4 flush pulse", tx_flush, 1);
    chk("R4 flag after flush", flags[3], 0);
    tx_level = '0; tick(1);
    chk("R4 flag set", flags[3], 1);
    chk("R4 flush ended", tx_flush, 0);
    addr_wr = 1; byte_req = 1; #1;
    chk("R5 hold high", scl_hold, 1);
    tick(1); addr_wr = 0;
    chk("R5 dry flag", flags[4], 1);
    chk("R1 ignored in read", flags[0], 0);
    tx_level = 5'd2; #1;
    chk("R5 hold released", scl_hold, 0);
    tick(1); byte_req = 0;
    status_in = 4'hA; nack = 1; tick(1); nack = 0;
    chk("R6 done", flags[5], 1);
    chk("R6 status", int'(status_out), 10);
    tick(2);

    // DMA read with burst 4
    dma_en = 1; clr = '1; tick(1); clr = '0; tx_level = 5'd14;
    addr_rd = 1; tick(1); addr_rd = 0; tick(3);
    chk("R7 single when short", int'({tx_sreq, tx_breq}), 2);
    tx_ack = 1; tick(1); tx_ack = 0; tx_level = 5'd10; tick(2);
    chk("R7 burst when room", int'({tx_sreq, tx_breq}), 1);
    tick(3);
    chk("R7 held", tx_breq, 1);
    nack = 1; tick(1); nack = 0;
    chk("R8 last burst", int'({tx_breq, tx_last}), 3);
    tx_ack = 1; tick(1); tx_ack = 0; tick(3);
    chk("R8 ends", int'({tx_sreq, tx_breq, tx_last}), 0);

    // DMA read with burst 1
    burst = 4'd1; tx_level = '0; tick(2);
    addr_rd = 1; tick(1); addr_rd = 0; tick(3);
    chk("R7 single burst1", int'({tx_sreq, tx_breq}), 2);
    nack = 1; tick(1); nack = 0;
    chk("R8 last single", int'({tx_sreq, tx_breq, tx_last}), 5);
    tx_ack = 1; tick(1); tx_ack = 0; tick(2);

    // RX DMA
    rx_level = 5'd3; tick(2);
    chk("R9 rx req", rx_sreq, 1);
    rx_ack = 1; rx_level = '0; tick(1); rx_ack = 0; tick(3);
    chk("R9 rx idle", rx_sreq, 0);
    dma_en = 0;

    // interrupt mask
    irq_en = '0; tick(1);
    chk("R10 masked", irq, 0);
    irq_en = 6'b100000; #1;
    chk("R10 enabled", irq, flags[5]);
    tick(4);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule